// File: doc/BRIEF.md
# Per-Line Interrupt Sense Configurator

This block takes a group of external interrupt lines and turns each one into a qualified request for a downstream interrupt controller. Each line has its own 6-bit sense code. The code selects whether the line fires on a low level, a high level, a falling edge, a rising edge or either edge. Every input first passes through a two-flop synchroniser, so all edge detection runs synchronously to the system clock.

In the edge modes, a detected edge sets a sticky status bit. Software clears that bit by writing a 1 to it. In the level modes, the status bit simply follows the qualified, synchronised input. A per-line enable bit gates the status onto the line's output. The enable is turned on through a set register and turned off through a clear register. Software reaches all state through a simple write port and a combinational read port.

Register map (word addresses):
- 0: enable-set. Writing 1 sets the enable bit; reading returns the enables.
- 1: enable-clear. Writing 1 clears the enable bit; reading returns the enables.
- 2: status. Reading returns the status bits; writing 1 clears a sticky bit.
- 3: reads as 0.
- 4+i: configuration register of line i.

Top module: `irq_sense_cfg`

## Requirements
- R1: After reset, all enables, configuration fields, status bits and outputs are 0.
- R2: Sense code 0x01 (active-low level) makes a line's status the inverse of its input. The status reflects a change of the input at most two clock edges after the change.
- R3: Sense code 0x02 (active-high level) makes a line's status equal to its input, with the same latency as R2.
- R4: Sense code 0x04 sets the line's sticky status on a falling edge, where the edge is seen between the last two synchronised samples. The bit stays set until software clears it.
- R5: Sense code 0x08 sets the line's sticky status on a rising edge.
- R6: Sense code 0x0C sets the line's sticky status on either edge.
- R7: Any other sense code, including 0, never sets status and never raises the output.
- R8: A write to address 4+i stores only bits 5:0 of the written data as line i's sense code. Bits 31:6 of the register always read as 0, whatever is written to them.
- R9: Writing address 0 sets each enable bit whose data bit is 1 and leaves the others unchanged. Reading address 0 or address 1 returns the enable vector, with bit i belonging to line i.
- R10: Writing address 1 clears each enable bit whose data bit is 1; bits written as 0 are unchanged.
- R11: Writing address 2 clears each sticky status bit written as 1, and bits written as 0 are unchanged. If an edge is detected in the same cycle as the clear, the edge wins and the bit stays set.
- R12: Each line's output equals its status bit ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NLINES | Raw external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DW | Combinational read data |
| irq_out | output | NLINES | Qualified, enabled interrupt per line |

## Verification
Every line is swept through all 64 sense codes. Each sweep drives a low-high-low pulse on the line, with a status clear between the two edges. This pattern separates level behaviour, which ignores the clear and tracks the pin, from edge behaviour, which stays sticky until cleared and reacts to one polarity or to both. It also shows that unlisted codes stay silent. Separate sequences cover the following:
- partial writes to the enable set and clear registers;
- gating of a pending status by the enable bit;
- writes to the upper configuration bits, which must have no effect;
- an edge arriving in the same cycle as its own clear.

// File: rtl/irq_sense_cfg.sv
module irq_sense_cfg #(
  parameter int NLINES = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic [NLINES-1:0] irq_out
);
  localparam int CW = 6;
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(2);
  localparam int CFG_BASE = 4;
  localparam logic [CW-1:0] C_LOW = 6'h01, C_HIGH = 6'h02, C_FALL = 6'h04,
                            C_RISE = 6'h08, C_BOTH = 6'h0C;

  logic [NLINES-1:0] s1, s2, s3, en, sticky, status, hit;
  logic [CW-1:0]     cfg [NLINES];

  wire [NLINES-1:0] set_mask = (wr_en && wr_addr == A_SET) ? wr_data[NLINES-1:0] : '0;
  wire [NLINES-1:0] clr_mask = (wr_en && wr_addr == A_CLR) ? wr_data[NLINES-1:0] : '0;
  wire [NLINES-1:0] w1c_mask = (wr_en && wr_addr == A_ST)  ? wr_data[NLINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      en <= '0; sticky <= '0;
    end else begin
      s1 <= irq_in;
      s2 <= s1;
      s3 <= s2;
      en <= (en | set_mask) & ~clr_mask;
      sticky <= hit | (sticky & ~w1c_mask);
    end
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    wire rise = s2[i] & ~s3[i];
    wire fall = ~s2[i] & s3[i];
    wire is_edge = (cfg[i] == C_FALL) || (cfg[i] == C_RISE) || (cfg[i] == C_BOTH);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(CFG_BASE + i)) cfg[i] <= wr_data[CW-1:0];
    end

    always_comb begin
      unique case (cfg[i])
        C_FALL:  hit[i] = fall;
        C_RISE:  hit[i] = rise;
        C_BOTH:  hit[i] = rise | fall;
        default: hit[i] = 1'b0;
      endcase
    end

    assign status[i] = (cfg[i] == C_LOW)  ? ~s2[i] :
                       (cfg[i] == C_HIGH) ?  s2[i] :
                       is_edge            ?  sticky[i] : 1'b0;

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i] != C_LOW && cfg[i] != C_HIGH && !is_edge) |-> !irq_out[i]);
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[i] == C_RISE && rise && !(wr_en && wr_addr == ADDR_W'(CFG_BASE + i)))
        |=> status[i]);
  end

  assign irq_out = status & en;

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_SET || rd_addr == A_CLR) rd_data[NLINES-1:0] = en;
    else if (rd_addr == A_ST) rd_data[NLINES-1:0] = status;
    else
      for (int i = 0; i < NLINES; i++)
        if (rd_addr == ADDR_W'(CFG_BASE + i)) rd_data[CW-1:0] = cfg[i];
  end

  p_enset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_SET) |=> ((en & $past(wr_data[NLINES-1:0])) == $past(wr_data[NLINES-1:0])));
  p_enclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) |=> ((en & $past(wr_data[NLINES-1:0])) == '0));
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sticky) & ~$past(w1c_mask)) & ~sticky) == '0));
  p_cfg_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= ADDR_W'(CFG_BASE)) |-> (rd_data[DW-1:CW] == '0));
endmodule

// File: tb/sim_irq_sense_cfg.sv
module sim_irq_sense_cfg;
  localparam int N = 4, DW = 32, AW = 3;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_in = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [N-1:0] irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_sense_cfg #(.NLINES(N), .DW(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic wait_sync();
    repeat (3) @(negedge clk);
  endtask

  logic [DW-1:0] v;
  bit lvl;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 enables", v, 0);
    rd(2, v); chk("R1 status", v, 0);
    for (int i = 0; i < N; i++) begin rd(4 + i, v); chk("R1 cfg", v, 0); end
    chk("R1 irq_out", DW'(irq_out), 0);

    // Sweep every line through every code: R2..R8, R11, R12
    for (int ln = 0; ln < N; ln++) begin
      wr(1, '1);
      wr(0, DW'(1) << ln);
      for (int c = 0; c < 64; c++) begin
        irq_in = '0;
        wr(4 + ln, 32'hFFFF_FFC0 | DW'(c));
        rd(4 + ln, v); chk("R8 cfg readback", v, DW'(c));
        wait_sync();
        wr(2, '1);
        lvl = (c == 1);
        rd(2, v); chk("R2/R7 status low input", v, DW'(lvl) << ln);
        chk("R12 out low input", DW'(irq_out), DW'(lvl) << ln);
        irq_in[ln] = 1;
        wait_sync();
        lvl = (c == 2) || (c == 8) || (c == 12);
        rd(2, v); chk("R3/R5/R6 status after rise", v, DW'(lvl) << ln);
        chk("R12 out after rise", DW'(irq_out), DW'(lvl) << ln);
        wr(2, '1);
        lvl = (c == 2);
        rd(2, v); chk("R11 status after clear", v, DW'(lvl) << ln);
        irq_in[ln] = 0;
        wait_sync();
        lvl = (c == 1) || (c == 4) || (c == 12);
        rd(2, v); chk("R2/R4/R6 status after fall", v, DW'(lvl) << ln);
        chk("R7 out after fall", DW'(irq_out), DW'(lvl) << ln);
        wr(2, '1);
      end
      wr(4 + ln, 0);
    end

    // R9 / R10 enable set and clear
    wr(1, '1);
    wr(0, 32'h5);
    rd(0, v); chk("R9 set readback", v, 32'h5);
    rd(1, v); chk("R9 readback at clear addr", v, 32'h5);
    wr(0, 32'h0);
    rd(0, v); chk("R9 zero write no effect", v, 32'h5);
    wr(0, 32'h2);
    rd(0, v); chk("R9 additional set", v, 32'h7);
    wr(1, 32'h1);
    rd(0, v); chk("R10 clear one", v, 32'h6);
    wr(1, 32'h0);
    rd(0, v); chk("R10 zero write no effect", v, 32'h6);

    // R12 gating of a pending status
    wr(4, 32'h08);
    irq_in[0] = 1; wait_sync();
    rd(2, v); chk("R5 pending while disabled", v & 32'h1, 32'h1);
    chk("R12 gated off", DW'(irq_out[0]), 0);
    wr(0, 32'h1);
    chk("R12 enabled on", DW'(irq_out[0]), 1);
    wr(2, 32'h0);
    rd(2, v); chk("R11 zero write keeps", v & 32'h1, 32'h1);
    wr(2, 32'h1);
    chk("R11 cleared", DW'(irq_out[0]), 0);

    // R11 edge wins over simultaneous clear
    irq_in[0] = 0; wait_sync();
    @(negedge clk); irq_in[0] = 1;
    @(negedge clk);
    wr(2, 32'h1);
    rd(2, v); chk("R11 edge wins", v & 32'h1, 32'h1);

    // R8 address 3 and upper bits
    rd(3, v); chk("R8 unused addr", v, 0);
    wr(5, 32'hABCD_EF00);
    rd(5, v); chk("R8 upper bits dropped", v, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule